// File: doc/BRIEF.md
# Posted write buffer with stall

This block sits between a write-back cache or processor core and main memory. It takes processor writes at core speed into a small first-in first-out queue. Each queued entry carries an address, a data word and byte enables. The processor can go on executing while the queue drains to memory in the background, one entry per accepted handshake, until nothing is left. When every slot is occupied, the block raises a write stall, and the processor must hold its write until an entry has gone out.

Queued data is never forwarded to reads. Before issuing a memory read, the processor presents the read address on a check port. If any pending entry holds that word address, the block raises a read stall. The stall stays high until the matching entry has been handed to memory. Memory reads themselves are handled elsewhere. The memory side is a valid/ready write port that presents the oldest entry and removes it only when ready is high.

Top module: `post_wbuf`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, mem_valid_o, wr_stall_o and rd_stall_o are 0.
- R2: mem_valid_o is 1 exactly when at least one entry is pending. A write accepted at a clock edge first appears on the memory port in the cycle after that edge, never in the cycle of its own acceptance.
- R3: Entries leave on the memory port in the order they were accepted. The address, data and byte enables of each are unchanged.
- R4: While mem_valid_o is 1 and mem_ready_i is 0, mem_valid_o stays 1 at the next edge and mem_addr_o, mem_data_o and mem_be_o keep their values.
- R5: An entry is removed only at an edge where mem_valid_o and mem_ready_i are both 1. Every accepted write is presented exactly once, so the number of memory handshakes equals the number of accepted writes.
- R6: wr_stall_o is 1 exactly when DEPTH entries are pending. A write offered while wr_stall_o is 1 is not accepted and never reaches the memory port.
- R7: At an edge that both accepts a write and completes a memory handshake, the number of pending entries is unchanged.
- R8: rd_stall_o is 1 exactly when rd_check_i is 1 and rd_addr_i equals the address of any pending entry, whether or not that entry is the oldest. It falls in the cycle after the last matching entry is handed to memory.
- R9: With mem_ready_i held at 0, DEPTH writes offered on consecutive cycles are all accepted, one per cycle, before wr_stall_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Processor offers a write |
| wr_addr_i | input | ADDR_W | Word address of the write |
| wr_data_i | input | DATA_W | Write data |
| wr_be_i | input | DATA_W/8 | Byte enables of the write |
| wr_stall_o | output | 1 | Queue full; the offered write is not taken |
| rd_check_i | input | 1 | Processor is about to read rd_addr_i |
| rd_addr_i | input | ADDR_W | Word address of the intended read |
| rd_stall_o | output | 1 | Read address matches a pending entry |
| mem_valid_o | output | 1 | Oldest pending entry is presented |
| mem_addr_o | output | ADDR_W | Address of the presented entry |
| mem_data_o | output | DATA_W | Data of the presented entry |
| mem_be_o | output | DATA_W/8 | Byte enables of the presented entry |
| mem_ready_i | input | 1 | Memory takes the presented entry at this edge |

## Verification
Some properties are checked on every cycle. The queue never takes a write while full and never pops while empty. The slot valid bits always agree with the occupancy count. The presented entry holds steady while memory back-pressures. Either stall implies pending data. Only the bench's scenarios can show the rest: first-in first-out order with intact fields, the one-cycle latency from acceptance to presentation, dropping of writes offered while stalled, read stalls against non-head entries, and equal counts of accepted and drained writes. The bench shows these by sweeping write density against memory ready duty over a small address set, with a reference queue in the bench.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // pointer width for a slot index, at least one bit
  function automatic int idx_w(input int depth);
    return (depth > 2) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
  parameter int W     = 52,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic [W-1:0] slot_o [DEPTH],
  output logic [DEPTH-1:0] valid_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PTR_W = wbuf_pkg::idx_w(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      valid_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wp_q]   <= din_i;
        valid_q[wp_q] <= 1'b1;
        wp_q          <= nxt(wp_q);
      end
      if (pop_i) begin
        valid_q[rp_q] <= 1'b0;
        rp_q          <= nxt(rp_q);
      end
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o  = mem_q[rp_q];
  assign slot_o  = mem_q;
  assign valid_o = valid_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(DEPTH)) |-> !push_i);
  // R5
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> !pop_i);
  // R7
  valid_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(valid_q) == int'(cnt_q));
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int W      = 52,
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      slot_i [DEPTH],
  input  logic [DEPTH-1:0]  valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [DEPTH-1:0] eq;

  // address sits in the top bits of each entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (slot_i[g][W-1 -: ADDR_W] == addr_i);
  end

  assign hit_o = |eq;

  // R8
  match_needs_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (valid_i != '0));
endmodule

// File: rtl/post_wbuf.sv
module post_wbuf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_valid_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [DATA_W/8-1:0] wr_be_i,
  output logic                wr_stall_o,
  input  logic                rd_check_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic                rd_stall_o,
  output logic                mem_valid_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_data_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  input  logic                mem_ready_i
);
  localparam int BE_W = DATA_W / 8;
  localparam int EW   = ADDR_W + BE_W + DATA_W;

  logic          push, pop, full, empty, hit;
  logic [EW-1:0] head;
  logic [EW-1:0] slots [DEPTH];
  logic [DEPTH-1:0] vld;

  assign push = wr_valid_i && !full;
  assign pop  = !empty && mem_ready_i;

  wbuf_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   ({wr_addr_i, wr_be_i, wr_data_i}),
    .pop_i   (pop),
    .dout_o  (head),
    .slot_o  (slots),
    .valid_o (vld),
    .full_o  (full),
    .empty_o (empty)
  );

  wbuf_match #(.W(EW), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slot_i  (slots),
    .valid_i (vld),
    .addr_i  (rd_addr_i),
    .hit_o   (hit)
  );

  assign mem_valid_o = !empty;
  assign {mem_addr_o, mem_be_o, mem_data_o} = head;
  assign wr_stall_o  = full;
  assign rd_stall_o  = rd_check_i && hit;

  // R4
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_data_o) && $stable(mem_be_o)));
  // R6
  stall_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stall_o |-> mem_valid_o);
  // R8
  rd_stall_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stall_o |-> mem_valid_o);
endmodule

// File: tb/post_wbuf_tb.sv
module post_wbuf_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int DEPTH  = 4;
  localparam int EW     = ADDR_W + BE_W + DATA_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_valid = 0, rd_check = 0, mem_ready = 0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [BE_W-1:0]   wr_be = '0;
  logic wr_stall, rd_stall, mem_valid;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data;
  logic [BE_W-1:0]   mem_be;

  always #5 clk = ~clk;

  post_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_be_i(wr_be),
    .wr_stall_o(wr_stall),
    .rd_check_i(rd_check), .rd_addr_i(rd_addr), .rd_stall_o(rd_stall),
    .mem_valid_o(mem_valid), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_be_o(mem_be), .mem_ready_i(mem_ready)
  );

  int nvec = 0, nfail = 0;
  int n_acc = 0, n_pop = 0;
  logic [EW-1:0] q [$];
  logic          prev_hold = 0;
  logic [EW-1:0] prev_head = '0;
  logic [31:0]   seq = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive after the edge, check, then advance the reference queue
  task automatic cyc(input logic wv, input logic [ADDR_W-1:0] wa, input logic rc,
                     input logic [ADDR_W-1:0] ra, input logic rdy);
    logic exp_rs;
    logic acc, pp;
    @(posedge clk);
    #2;
    wr_valid = wv; wr_addr = wa; wr_data = 32'hA5000000 + seq;
    wr_be = BE_W'(seq) | 4'b0001;
    rd_check = rc; rd_addr = ra; mem_ready = rdy;
    #1;
    chk("R2 mem_valid", 64'(mem_valid), 64'(q.size() > 0));
    if (q.size() > 0)
      chk("R3 head", 64'({mem_addr, mem_be, mem_data}), 64'(q[0]));
    chk("R6 wr_stall", 64'(wr_stall), 64'(q.size() == DEPTH));
    exp_rs = 1'b0;
    foreach (q[i]) if (q[i][EW-1 -: ADDR_W] == ra) exp_rs = rc;
    chk("R8 rd_stall", 64'(rd_stall), 64'(exp_rs));
    if (prev_hold)
      chk("R4 hold", 64'({mem_valid, mem_addr, mem_be, mem_data}), 64'({1'b1, prev_head}));
    acc = wv && (q.size() < DEPTH);
    pp  = (q.size() > 0) && rdy;
    prev_hold = (q.size() > 0) && !rdy;
    if (q.size() > 0) prev_head = q[0];
    if (pp) begin void'(q.pop_front()); n_pop++; end
    if (acc) begin q.push_back({wa, wr_be, wr_data}); n_acc++; end
    seq++;
  endtask

  initial begin
    #100000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #23;
    chk("R1 mem_valid in reset", 64'(mem_valid), 0);
    chk("R1 wr_stall in reset", 64'(wr_stall), 0);
    chk("R1 rd_stall in reset", 64'(rd_stall), 0);
    rst_ni = 1'b1;
    cyc(0, 0, 1, 0, 0);  // R1 first cycle after reset, checked by cyc

    // R2: single write, visible only in the next cycle
    cyc(1, 16'h0010, 0, 0, 1);
    chk("R2 no same-cycle bypass", 64'(mem_valid), 0);
    cyc(0, 0, 1, 16'h0010, 1);
    chk("R2 presented next cycle", 64'(mem_valid), 1);
    cyc(0, 0, 1, 16'h0010, 1);
    chk("R8 stall drops after drain", 64'(rd_stall), 0);

    // R9: back-to-back fill with memory stalled; R6: fifth write dropped
    for (int k = 0; k < DEPTH; k++) begin
      cyc(1, 16'h0100 + 16'(k), 0, 0, 0);
      chk("R9 no stall while filling", 64'(wr_stall), 0);
    end
    cyc(1, 16'h0BAD, 1, 16'h0102, 0);
    chk("R6 stall when full", 64'(wr_stall), 1);
    chk("R8 stall on non-head entry", 64'(rd_stall), 1);
    // R7: push and pop together once not full
    cyc(0, 0, 1, 16'h0BAD, 1);
    chk("R6 dropped write not pending", 64'(rd_stall), 0);
    cyc(1, 16'h0200, 0, 0, 1);
    chk("R7 not full before swap", 64'(wr_stall), 0);
    cyc(1, 16'h0201, 0, 0, 0);
    chk("R7 count kept by push with pop", 64'(wr_stall), 0);
    cyc(0, 0, 0, 0, 0);
    chk("R7 full after extra push", 64'(wr_stall), 1);
    for (int k = 0; k < DEPTH + 2; k++) cyc(0, 0, 1, 16'h0201, 1);

    // sweep write density against ready duty over a small address set
    for (int duty = 0; duty < 4; duty++)
      for (int dens = 0; dens < 4; dens++)
        for (int c = 0; c < 40; c++)
          cyc(((c + dens) % 4) <= dens, 16'((c * 5 + dens) % 8), (c % 3) != 2,
              16'((c * 3 + duty) % 8), (c % 4) <= duty - (c % 7 == 0 ? 1 : 0));

    for (int k = 0; k < DEPTH + 2; k++) cyc(0, 0, 0, 0, 1);
    chk("R5 handshakes equal accepted writes", 64'(n_pop), 64'(n_acc));
    chk("R2 empty after drain", 64'(mem_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule